// File: doc/BRIEF.md
# Time-Scheduled Square-Wave Pin with Edge Capture

This block drives one timing pin from a free-running 64-bit time counter. Software loads an absolute start time and a half-period, both in counter ticks, then issues a start strobe. The pin flips when the counter reaches the start time. After that it flips again each time another half-period has elapsed, which gives a 50% duty square wave. The output frequency is 1 / (2 × half-period × tick). With an 8 ns tick and a 32-bit half-period, the longest full period is about 68.7 s. A start strobe whose start time is not strictly later than the current time is dropped. A stop strobe forces the pin low and halts the schedule.

The same pin can be turned into an input with a mode select. In that mode the block passes the pin through a two-flop synchroniser and detects both rising and falling edges. On each edge it copies the current counter value into a single timestamp register. There is no queue and no notification, so each new edge replaces the previous value. The synchroniser delay is not subtracted from the recorded value.

Top module: `sched_sqwave`

## Requirements
- R1: After reset the pin output is low, the capture register holds zero, and the pin is driven as an output while the mode select is low.
- R2: A start strobe arms the schedule only when start time > current time. The first toggle, from low to high, happens at the clock edge where the sampled time first reaches or passes the start time.
- R3: Once armed, the pin toggles again each time the sampled time reaches the previous toggle time plus the half-period.
- R4: A start strobe whose start time is equal to or earlier than the current time is ignored, and the pin does not move.
- R5: A stop strobe drives the pin low and disarms the schedule on the next clock edge. Stop wins over a start strobe in the same cycle.
- R6: The half-period is taken at the accepted start strobe. Later changes on the half-period input do not alter the running spacing.
- R7: While the mode select is high (capture mode), the pin output enable is low, the pin output is held low, the schedule is disarmed and start strobes are ignored.
- R8: In capture mode, every rising and every falling edge on the pin input loads the capture register. The value loaded is the time sampled at the second clock edge after the edge that first samples the new input level, so the captured time is the first-sampling time plus 2 ticks when time advances one tick per cycle.
- R9: The capture register holds one value only, and each new edge overwrites it. Pin input edges seen while not in capture mode leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| now_i | input | 64 | Current time counter, in ticks |
| start_at_i | input | 64 | Absolute time of the first toggle |
| half_per_i | input | 32 | Ticks between two successive toggles |
| cmd_start_i | input | 1 | Start strobe, one cycle |
| cmd_stop_i | input | 1 | Stop strobe, one cycle |
| capture_mode_i | input | 1 | 1 = pin is a capture input, 0 = pin is the square-wave output |
| pin_in_i | input | 1 | Pin level as an input (asynchronous) |
| pin_out_o | output | 1 | Pin level as an output |
| pin_oe_o | output | 1 | Pin output enable |
| capt_ts_o | output | 64 | Time of the most recent captured edge |

## Verification
The assertions check four things on every cycle:
- A pin change is preceded by an armed schedule whose due time had been reached.
- Arming only follows a start strobe carrying a strictly later time.
- Stop and capture mode both leave the pin low on the next cycle.
- The capture register moves only when capture mode was active.

The exact tick of each toggle needs the bench's scenarios. So do the spacing held after a half-period change, the rejection of equal and past start times, and the two-cycle capture offset on both edge polarities.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

    localparam int unsigned DEF_TIME_W  = 64;
    localparam int unsigned DEF_HALF_W  = 32;
    localparam int unsigned DEF_SYNC_N  = 2;

    // Scheduler command, resolved once per cycle from the strobes
    typedef enum logic [1:0] {
        SCMD_IDLE = 2'd0,
        SCMD_ARM  = 2'd1,
        SCMD_HALT = 2'd2
    } sched_cmd_e;

    // Halt beats arm; an arm needs a start time in the future
    function automatic sched_cmd_e resolve_cmd(
        input logic stop,
        input logic capture_mode,
        input logic start,
        input logic start_in_future
    );
        if (stop || capture_mode)
            return SCMD_HALT;
        else if (start && start_in_future)
            return SCMD_ARM;
        else
            return SCMD_IDLE;
    endfunction

endpackage

// File: rtl/sqw_sync.sv
module sqw_sync #(
    parameter int unsigned STAGES = sqw_pkg::DEF_SYNC_N
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sqw_sched.sv
module sqw_sched
    import sqw_pkg::*;
#(
    parameter int unsigned TIME_W = DEF_TIME_W,
    parameter int unsigned HALF_W = DEF_HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] now_i,
    input  logic [TIME_W-1:0] start_at_i,
    input  logic [HALF_W-1:0] half_i,
    input  sched_cmd_e        cmd_i,
    output logic              pin_o,
    output logic              armed_o,
    output logic [TIME_W-1:0] next_edge_o
);
    localparam int unsigned PAD_W = TIME_W - HALF_W;

    logic              armed_q;
    logic              pin_q;
    logic [TIME_W-1:0] next_q;
    logic [HALF_W-1:0] half_q;
    logic              due;

    assign due = armed_q && (now_i >= next_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            pin_q   <= 1'b0;
            next_q  <= '0;
            half_q  <= '0;
        end else begin
            unique case (cmd_i)
                SCMD_HALT: begin
                    armed_q <= 1'b0;
                    pin_q   <= 1'b0;
                end
                SCMD_ARM: begin
                    armed_q <= 1'b1;
                    next_q  <= start_at_i;
                    half_q  <= half_i;
                end
                default: begin
                    if (due) begin
                        pin_q  <= ~pin_q;
                        next_q <= next_q + {{PAD_W{1'b0}}, half_q};
                    end
                end
            endcase
        end
    end

    assign pin_o       = pin_q;
    assign armed_o     = armed_q;
    assign next_edge_o = next_q;
endmodule

// File: rtl/sqw_capture.sv
module sqw_capture #(
    parameter int unsigned TIME_W = sqw_pkg::DEF_TIME_W,
    parameter int unsigned SYNC_N = sqw_pkg::DEF_SYNC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic              pin_i,
    input  logic [TIME_W-1:0] now_i,
    output logic [TIME_W-1:0] ts_o
);
    logic              pin_sync;
    logic              pin_prev_q;
    logic              any_edge;
    logic [TIME_W-1:0] ts_q;

    sqw_sync #(.STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_i),
        .q_o (pin_sync)
    );

    assign any_edge = pin_sync ^ pin_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_prev_q <= 1'b0;
            ts_q       <= '0;
        end else begin
            pin_prev_q <= pin_sync;
            if (enable_i && any_edge)
                ts_q <= now_i;
        end
    end

    assign ts_o = ts_q;
endmodule

// File: rtl/sched_sqwave.sv
module sched_sqwave
    import sqw_pkg::*;
#(
    parameter int unsigned TIME_W = DEF_TIME_W,
    parameter int unsigned HALF_W = DEF_HALF_W,
    parameter int unsigned SYNC_N = DEF_SYNC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] now_i,
    input  logic [TIME_W-1:0] start_at_i,
    input  logic [HALF_W-1:0] half_per_i,
    input  logic              cmd_start_i,
    input  logic              cmd_stop_i,
    input  logic              capture_mode_i,
    input  logic              pin_in_i,
    output logic              pin_out_o,
    output logic              pin_oe_o,
    output logic [TIME_W-1:0] capt_ts_o
);
    sched_cmd_e        sched_cmd;
    logic              start_future;
    logic              sched_pin;
    logic              sched_armed;
    logic [TIME_W-1:0] sched_next;

    assign start_future = (start_at_i > now_i);
    assign sched_cmd    = resolve_cmd(cmd_stop_i, capture_mode_i,
                                      cmd_start_i, start_future);

    sqw_sched #(.TIME_W(TIME_W), .HALF_W(HALF_W)) u_sched (
        .clk         (clk),
        .rst         (rst),
        .now_i       (now_i),
        .start_at_i  (start_at_i),
        .half_i      (half_per_i),
        .cmd_i       (sched_cmd),
        .pin_o       (sched_pin),
        .armed_o     (sched_armed),
        .next_edge_o (sched_next)
    );

    sqw_capture #(.TIME_W(TIME_W), .SYNC_N(SYNC_N)) u_capt (
        .clk      (clk),
        .rst      (rst),
        .enable_i (capture_mode_i),
        .pin_i    (pin_in_i),
        .now_i    (now_i),
        .ts_o     (capt_ts_o)
    );

    assign pin_out_o = sched_pin;
    assign pin_oe_o  = ~capture_mode_i;
endmodule

// File: rtl/sqw_chk.sv
module sqw_chk #(
    parameter int unsigned TIME_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic [TIME_W-1:0] now_i,
    input logic [TIME_W-1:0] start_at_i,
    input logic              cmd_start_i,
    input logic              cmd_stop_i,
    input logic              capture_mode_i,
    input logic              pin_out_o,
    input logic [TIME_W-1:0] capt_ts_o,
    input logic              sched_armed,
    input logic [TIME_W-1:0] sched_next
);
    // R2
    arm_needs_future_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sched_armed) |-> $past(cmd_start_i && (start_at_i > now_i)));

    // R3
    toggle_when_due_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(pin_out_o) && !$past(cmd_stop_i) && !$past(capture_mode_i))
        |-> $past(sched_armed && (now_i >= sched_next)));

    // R5
    stop_forces_low_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_stop_i |=> (!pin_out_o && !sched_armed));

    // R7
    capmode_pin_low_chk: assert property (@(posedge clk) disable iff (rst)
        capture_mode_i |=> (!pin_out_o && !sched_armed));

    // R9
    capt_only_in_mode_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(capt_ts_o) |-> $past(capture_mode_i));
endmodule

bind sched_sqwave sqw_chk #(.TIME_W(TIME_W)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .now_i          (now_i),
    .start_at_i     (start_at_i),
    .cmd_start_i    (cmd_start_i),
    .cmd_stop_i     (cmd_stop_i),
    .capture_mode_i (capture_mode_i),
    .pin_out_o      (pin_out_o),
    .capt_ts_o      (capt_ts_o),
    .sched_armed    (sched_armed),
    .sched_next     (sched_next)
);

// File: tb/sched_sqwave_tb_top.sv
`timescale 1ns/1ps
module sched_sqwave_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] now_i = 64'd1000;
    logic [63:0] start_at_i = '0;
    logic [31:0] half_per_i = '0;
    logic        cmd_start_i = 1'b0;
    logic        cmd_stop_i = 1'b0;
    logic        capture_mode_i = 1'b0;
    logic        pin_in_i = 1'b0;
    logic        pin_out_o;
    logic        pin_oe_o;
    logic [63:0] capt_ts_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    sched_sqwave dut_i (
        .clk            (clk),
        .rst            (rst),
        .now_i          (now_i),
        .start_at_i     (start_at_i),
        .half_per_i     (half_per_i),
        .cmd_start_i    (cmd_start_i),
        .cmd_stop_i     (cmd_stop_i),
        .capture_mode_i (capture_mode_i),
        .pin_in_i       (pin_in_i),
        .pin_out_o      (pin_out_o),
        .pin_oe_o       (pin_oe_o),
        .capt_ts_o      (capt_ts_o)
    );

    // 200 MHz
    initial forever #2.5 clk = ~clk;

    // time counter: one tick per cycle, updated away from the rising edge
    initial forever begin
        @(negedge clk);
        now_i <= now_i + 64'd1;
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Arms with start = (time seen at the strobe edge) + off; returns that start
    task automatic arm(input longint off, input logic [31:0] h,
                       input bit with_stop, output logic [63:0] s);
        @(negedge clk);
        s = now_i + 64'd1 + 64'(off);
        start_at_i  = s;
        half_per_i  = h;
        cmd_start_i = 1'b1;
        cmd_stop_i  = with_stop;
        @(negedge clk);
        cmd_start_i = 1'b0;
        cmd_stop_i  = 1'b0;
    endtask

    task automatic stop_now();
        @(negedge clk);
        cmd_stop_i = 1'b1;
        @(negedge clk);
        cmd_stop_i = 1'b0;
    endtask

    task automatic expect_edges(input logic [63:0] first, input logic [31:0] h,
                                input int n, input string tag);
        logic last;
        int got;
        int waited;
        last = pin_out_o;
        got = 0;
        waited = 0;
        while (got < n && waited < 400) begin
            @(posedge clk); #1;
            waited++;
            if (pin_out_o !== last) begin
                chk(now_i == first + 64'(got) * 64'(h), tag, now_i,
                    first + 64'(got) * 64'(h));
                chk(pin_out_o == ((got % 2) == 0), tag, pin_out_o, (got % 2) == 0);
                last = pin_out_o;
                got++;
            end
        end
        if (got < n) chk(1'b0, tag, got, n);
    endtask

    task automatic expect_quiet(input int cycles, input string tag);
        int moves;
        moves = 0;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk); #1;
            if (pin_out_o !== 1'b0) moves++;
        end
        chk(moves == 0, tag, moves, 0);
    endtask

    task automatic t_reset();
        @(posedge clk); #1;
        // R1
        chk(pin_out_o == 1'b0, "R1 pin low", pin_out_o, 0);
        chk(capt_ts_o == 64'd0, "R1 capture zero", capt_ts_o, 0);
        chk(pin_oe_o == 1'b1, "R1 output enable", pin_oe_o, 1);
    endtask

    task automatic t_basic();
        logic [63:0] s;
        arm(10, 32'd4, 1'b0, s);
        // R2 first rise at start, R3 spacing of 4
        expect_edges(s, 32'd4, 6, "R2 R3 schedule h=4");
        stop_now();
        arm(3, 32'd1, 1'b0, s);
        expect_edges(s, 32'd1, 4, "R3 schedule h=1");
        stop_now();
    endtask

    task automatic t_late_start();
        logic [63:0] s;
        // R4 start equal to current time
        arm(0, 32'd2, 1'b0, s);
        expect_quiet(30, "R4 start equal to now");
        // R4 start in the past
        arm(-5, 32'd2, 1'b0, s);
        expect_quiet(30, "R4 start in past");
    endtask

    task automatic t_stop();
        logic [63:0] s;
        arm(5, 32'd6, 1'b0, s);
        expect_edges(s, 32'd6, 1, "R5 pre-stop rise");
        @(negedge clk);
        cmd_stop_i = 1'b1;
        @(posedge clk); #1;
        chk(pin_out_o == 1'b0, "R5 stop forces low", pin_out_o, 0);
        @(negedge clk);
        cmd_stop_i = 1'b0;
        expect_quiet(30, "R5 stays stopped");
        // R5 stop and start together
        arm(4, 32'd2, 1'b1, s);
        expect_quiet(30, "R5 stop wins over start");
    endtask

    task automatic t_latch();
        logic [63:0] s;
        arm(6, 32'd3, 1'b0, s);
        half_per_i = 32'd9;
        // R6 spacing keeps the value present at the start strobe
        expect_edges(s, 32'd3, 5, "R6 half-period latched");
        stop_now();
    endtask

    task automatic t_capmode();
        logic [63:0] s;
        arm(5, 32'd2, 1'b0, s);
        capture_mode_i = 1'b1;
        #1;
        // R7
        chk(pin_oe_o == 1'b0, "R7 output enable low", pin_oe_o, 0);
        expect_quiet(30, "R7 schedule halted");
        arm(4, 32'd2, 1'b0, s);
        expect_quiet(30, "R7 start ignored");
    endtask

    task automatic toggle_and_check(input logic lvl, input string tag);
        logic [63:0] r;
        @(negedge clk);
        r = now_i;
        pin_in_i = lvl;
        repeat (2) @(posedge clk);
        #1;
        chk(capt_ts_o != r + 64'd3, {tag, " not early"}, capt_ts_o, r + 64'd3);
        @(posedge clk); #1;
        chk(capt_ts_o == r + 64'd3, tag, capt_ts_o, r + 64'd3);
    endtask

    task automatic t_capture();
        logic [63:0] held;
        capture_mode_i = 1'b1;
        repeat (4) @(negedge clk);
        // R8 rising edge, then falling edge
        toggle_and_check(1'b1, "R8 rise capture");
        repeat (5) @(negedge clk);
        // R9 a later edge overwrites the register
        toggle_and_check(1'b0, "R8 R9 fall capture overwrites");
        repeat (5) @(negedge clk);
        capture_mode_i = 1'b0;
        held = capt_ts_o;
        pin_in_i = 1'b1;
        repeat (8) @(posedge clk);
        #1;
        chk(capt_ts_o == held, "R9 no capture in output mode", capt_ts_o, held);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_late_start();
        t_stop();
        t_latch();
        t_capmode();
        t_capture();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule